// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block models how a NOR-style flash array reports its progress during a word program or a sector erase. The host issues single-cycle command strobes for program, sector erase and return-to-read, together with a word address and, for a program, the data to write. A stub array engine runs one programming pulse per clock. The engine raises `cellVerified` on the pulse that verifies. The block also watches a low-supply flag, and it checks each command against per-sector protect flags and against the current cell contents.

While an operation runs, the data bus carries a status word instead of array data. Status reads toggle one bit of that word. Two latched fault bits report a failed program or erase and a supply that is too low. After a fault, the block stays in status-read mode until the host issues the return-to-read command. When an operation finishes cleanly, the bus goes back to array data at once, so the new contents can be read.

The array holds `NUM_SECTORS` sectors of `SECTOR_WORDS` words. An erased word reads as all ones. A program can only clear bits.

Top module: `flash_status_unit`

## Requirements
- R1: After reset every array word reads all ones, `busy` is low and `rdData` shows the array word at `addr`.
- R2: A program command on an unprotected word that needs no 0-to-1 change raises `busy`. On the pulse where `cellVerified` is high the word becomes old AND data, `busy` drops, and `rdData` shows the new word. If program and erase are strobed together, program wins.
- R3: A sector erase command on an unprotected sector sets every word of the sector (address bits above the word index) to all ones once verified.
- R4: While `busy` is high, `rdData` carries the status word: bit 6 is the toggle bit, bit 5 is the program/erase failure, bit 3 is the supply fault, and all other bits are 0. Bits 5 and 3 read 0 during the operation.
- R5: Bit 6 inverts after each clock in which `rdStrobe` is high while busy. Outside busy it holds its value.
- R6: If `cellVerified` does not come within `PULSE_LIMIT` busy cycles, bit 5 sets, the block enters status-read mode and the word is unchanged. A verify on the last allowed cycle still succeeds.
- R7: A program that would turn any 0 bit of the target word into 1 sets bit 5 and enters status-read mode the next cycle, without starting pulses and without changing the array.
- R8: A program or sector erase aimed at a sector whose `protectMask` bit is 1 sets bit 5, enters status-read mode and leaves the array unchanged.
- R9: `vppLow` high during any busy cycle aborts the operation, sets bit 3, enters status-read mode and leaves the array unchanged. It takes precedence over `cellVerified` in the same cycle.
- R10: In status-read mode, program and erase commands are ignored. `cmdExit` clears bits 5 and 3 and the pulse count in one cycle, and returns to array reads.
- R11: While busy, all commands, `cmdExit` included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdProgram | input | 1 | Word program command strobe |
| cmdErase | input | 1 | Sector erase command strobe |
| cmdExit | input | 1 | Return-to-read command strobe |
| rdStrobe | input | 1 | Host status/data read strobe |
| addr | input | ADDR_W (4) | Word address; upper bits select the sector |
| wrData | input | DATA_W (8) | Program data |
| protectMask | input | NUM_SECTORS (4) | Per-sector protect flags |
| vppLow | input | 1 | Programming supply too low |
| cellVerified | input | 1 | Stub engine: current pulse verified |
| rdData | output | DATA_W (8) | Array word, or status word when not in read mode |
| busy | output | 1 | Program or erase in progress |

## Verification
The embedded assertions check on every cycle that the fault bits stay clear while busy and that the pulse count never passes its limit. They also check that the toggle bit is frozen outside busy, that the exit command always lands in read mode, and that an aborted or failed operation sets its fault bit on the next cycle. Several properties can only be shown by the bench's scenarios: the array contents after each kind of operation, the exact number of busy cycles before a pulse-limit failure, the precedence of the supply fault over a verify, and the fact that commands issued while busy or faulted change nothing.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {ST_READ, ST_BUSY, ST_STATUS} modeT;

  typedef struct packed {
    logic startOp;
    logic opErase;
    logic countPulse;
    logic commitOp;
    logic setPeFail;
    logic setVppFail;
    logic clearErr;
  } ctrlStrobeT;

  localparam int TOGGLE_BIT  = 6;
  localparam int PEFAIL_BIT  = 5;
  localparam int VPPFAIL_BIT = 3;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdProgram,
  input  logic       cmdErase,
  input  logic       cmdExit,
  input  logic       vppLow,
  input  logic       cellVerified,
  input  logic       badProgram,
  input  logic       badErase,
  input  logic       pulseAtLimit,
  output ctrlStrobeT strobe,
  output modeT       mode
);
  modeT modeNxt;

  always_comb begin
    modeNxt = mode;
    strobe  = '0;
    case (mode)
      ST_READ: begin
        if (cmdProgram) begin
          if (badProgram) begin
            strobe.setPeFail = 1'b1;
            modeNxt = ST_STATUS;
          end else begin
            strobe.startOp = 1'b1;
            modeNxt = ST_BUSY;
          end
        end else if (cmdErase) begin
          if (badErase) begin
            strobe.setPeFail = 1'b1;
            modeNxt = ST_STATUS;
          end else begin
            strobe.startOp = 1'b1;
            strobe.opErase = 1'b1;
            modeNxt = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (vppLow) begin
          strobe.setVppFail = 1'b1;
          modeNxt = ST_STATUS;
        end else if (cellVerified) begin
          strobe.commitOp = 1'b1;
          modeNxt = ST_READ;
        end else if (pulseAtLimit) begin
          strobe.setPeFail = 1'b1;
          modeNxt = ST_STATUS;
        end else begin
          strobe.countPulse = 1'b1;
        end
      end
      ST_STATUS: begin
        if (cmdExit) begin
          strobe.clearErr = 1'b1;
          modeNxt = ST_READ;
        end
      end
      default: modeNxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= ST_READ;
    else       mode <= modeNxt;
  end

  // R10: exit from status-read mode always lands in read mode
  a_r10_exit_to_read: assert property (@(posedge clk) disable iff (!rstN)
    (mode == ST_STATUS && cmdExit) |=> (mode == ST_READ));

  // R11: a busy cycle with no verify, fault or limit stays busy whatever the commands
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mode == ST_BUSY && !vppLow && !cellVerified && !pulseAtLimit) |=> (mode == ST_BUSY));
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 4,
  parameter int PULSE_LIMIT  = 6,
  localparam int SECT_W    = $clog2(NUM_SECTORS),
  localparam int WORD_W    = $clog2(SECTOR_WORDS),
  localparam int ADDR_W    = SECT_W + WORD_W,
  localparam int NUM_WORDS = NUM_SECTORS * SECTOR_WORDS,
  localparam int CNT_W     = $clog2(PULSE_LIMIT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  input  logic                   busy,
  input  logic                   showStatus,
  input  logic                   rdStrobe,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_SECTORS-1:0] protectMask,
  output logic                   badProgram,
  output logic                   badErase,
  output logic                   pulseAtLimit,
  output logic [DATA_W-1:0]      rdData
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] memQ, memNxt;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic              opErase;
  logic [CNT_W-1:0]  pulseCnt;
  logic              peFail, vppFail, toggleQ;
  logic [DATA_W-1:0] statusWord;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int SEC = w / SECTOR_WORDS;
    logic hitErase, hitProg;
    assign hitErase = opErase && (opAddr[ADDR_W-1:WORD_W] == SECT_W'(SEC));
    assign hitProg  = !opErase && (opAddr == ADDR_W'(w));
    assign memNxt[w] = !strobe.commitOp ? memQ[w] :
                       hitErase ? {DATA_W{1'b1}} :
                       hitProg  ? (memQ[w] & opData) : memQ[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) memQ <= '1;
    else       memQ <= memNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr  <= '0;
      opData  <= '0;
      opErase <= 1'b0;
    end else if (strobe.startOp) begin
      opAddr  <= addr;
      opData  <= wrData;
      opErase <= strobe.opErase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 pulseCnt <= '0;
    else if (strobe.startOp || strobe.clearErr) pulseCnt <= '0;
    else if (strobe.countPulse)                pulseCnt <= pulseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearErr) begin
      peFail  <= 1'b0;
      vppFail <= 1'b0;
    end else begin
      if (strobe.setPeFail)  peFail  <= 1'b1;
      if (strobe.setVppFail) vppFail <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                toggleQ <= 1'b0;
    else if (busy && rdStrobe) toggleQ <= ~toggleQ;
  end

  assign pulseAtLimit = (pulseCnt == CNT_W'(PULSE_LIMIT - 1));
  assign badErase     = protectMask[addr[ADDR_W-1:WORD_W]];
  assign badProgram   = badErase || (|(wrData & ~memQ[addr]));

  always_comb begin
    statusWord = '0;
    statusWord[TOGGLE_BIT]  = toggleQ;
    statusWord[PEFAIL_BIT]  = peFail;
    statusWord[VPPFAIL_BIT] = vppFail;
  end

  assign rdData = showStatus ? statusWord : memQ[addr];

  // R4: fault bits are clear for the whole of an operation
  a_r4_busy_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!peFail && !vppFail));

  // R6: pulse counter never runs past the limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_W'(PULSE_LIMIT - 1));

  // R5: toggle bit frozen outside busy
  a_r5_toggle_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(toggleQ));

  // R9: supply fault request is latched next cycle
  a_r9_vpp_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setVppFail |=> vppFail);

  // R6: failure request is latched next cycle
  a_r6_pe_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPeFail |=> peFail);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 4,
  parameter int PULSE_LIMIT  = 6,
  localparam int ADDR_W = $clog2(NUM_SECTORS) + $clog2(SECTOR_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdProgram,
  input  logic                   cmdErase,
  input  logic                   cmdExit,
  input  logic                   rdStrobe,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_SECTORS-1:0] protectMask,
  input  logic                   vppLow,
  input  logic                   cellVerified,
  output logic [DATA_W-1:0]      rdData,
  output logic                   busy
);
  ctrlStrobeT strobe;
  modeT       mode;
  logic       badProgram, badErase, pulseAtLimit;

  fsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdProgram(cmdProgram), .cmdErase(cmdErase),
    .cmdExit(cmdExit), .vppLow(vppLow), .cellVerified(cellVerified),
    .badProgram(badProgram), .badErase(badErase), .pulseAtLimit(pulseAtLimit),
    .strobe(strobe), .mode(mode)
  );

  fsr_datapath #(
    .DATA_W(DATA_W), .NUM_SECTORS(NUM_SECTORS),
    .SECTOR_WORDS(SECTOR_WORDS), .PULSE_LIMIT(PULSE_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .showStatus(mode != ST_READ), .rdStrobe(rdStrobe), .addr(addr),
    .wrData(wrData), .protectMask(protectMask), .badProgram(badProgram),
    .badErase(badErase), .pulseAtLimit(pulseAtLimit), .rdData(rdData)
  );

  assign busy = (mode == ST_BUSY);
endmodule

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
  localparam int LIMIT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdProgram = 0, cmdErase = 0, cmdExit = 0, rdStrobe = 0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] protectMask = 4'b1000;
  logic       vppLow = 0, cellVerified = 0;
  logic [7:0] rdData;
  logic       busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_status_unit #(.PULSE_LIMIT(LIMIT)) u_flash_status_unit (
    .clk(clk), .rstN(rstN), .cmdProgram(cmdProgram), .cmdErase(cmdErase),
    .cmdExit(cmdExit), .rdStrobe(rdStrobe), .addr(addr), .wrData(wrData),
    .protectMask(protectMask), .vppLow(vppLow), .cellVerified(cellVerified),
    .rdData(rdData), .busy(busy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind 1 = program, 2 = erase; vc/vp = busy cycle of verify / low supply
  task automatic runOp(input int kind, input logic [3:0] a, input logic [7:0] d,
                       input int vc, input int vp, output int cycles);
    addr = a; wrData = d;
    cmdProgram = (kind == 1); cmdErase = (kind == 2);
    @(negedge clk);
    cmdProgram = 0; cmdErase = 0;
    cycles = 0;
    while (busy && cycles < 100) begin
      cellVerified = (cycles == vc);
      vppLow = (cycles == vp);
      @(negedge clk);
      cycles++;
    end
    cellVerified = 0; vppLow = 0;
    #1;
  endtask

  task automatic doExit();
    cmdExit = 1;
    @(negedge clk);
    cmdExit = 0;
    #1;
  endtask

  // {kind, addr, data, verifyCycle, vppCycle, expStatus(bit6 masked), expRead}
  localparam logic [45:0] VEC [9] = '{
    {2'd1, 4'd1,  8'hA5, 8'd2,  8'd99, 8'h00, 8'hA5},  // R2
    {2'd1, 4'd1,  8'h25, 8'd0,  8'd99, 8'h00, 8'h25},  // R2
    {2'd1, 4'd1,  8'hFF, 8'd0,  8'd99, 8'h20, 8'h25},  // R7
    {2'd1, 4'd13, 8'h00, 8'd0,  8'd99, 8'h20, 8'hFF},  // R8
    {2'd2, 4'd12, 8'h00, 8'd0,  8'd99, 8'h20, 8'hFF},  // R8
    {2'd1, 4'd5,  8'h0F, 8'd99, 8'd1,  8'h08, 8'hFF},  // R9
    {2'd1, 4'd6,  8'h3C, 8'd99, 8'd99, 8'h20, 8'hFF},  // R6
    {2'd2, 4'd1,  8'h00, 8'd3,  8'd99, 8'h00, 8'hFF},  // R3
    {2'd1, 4'd9,  8'h81, 8'd0,  8'd99, 8'h00, 8'h81}   // R2
  };

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic t0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 busy after reset", {7'd0, busy}, 8'h00);
    check("R1 erased word", rdData, 8'hFF);
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      logic [45:0] v;
      v = VEC[i];
      runOp(int'(v[45:44]), v[43:40], v[39:32], int'(v[31:24]), int'(v[23:16]), cyc);
      if (v[15:8] != 8'h00) begin
        check("R6/R7/R8/R9 status word", rdData & 8'hBF, v[15:8]);
        doExit();
      end
      check("R2/R3/R10 array read", rdData, v[7:0]);
      @(negedge clk);
    end

    // R4, R5, R11 during an operation that never verifies
    addr = 4'd2; wrData = 8'h00; cmdProgram = 1;
    @(negedge clk);
    cmdProgram = 0;
    #1;
    check("R4 fault bits clear while busy", rdData & 8'h28, 8'h00);
    check("R4 busy high", {7'd0, busy}, 8'h01);
    t0 = rdData[6];
    rdStrobe = 1;
    @(negedge clk); #1;
    check("R5 toggle after read 1", {7'd0, rdData[6]}, {7'd0, ~t0});
    t0 = rdData[6];
    cmdExit = 1;
    @(negedge clk); #1;
    check("R5 toggle after read 2", {7'd0, rdData[6]}, {7'd0, ~t0});
    check("R11 exit ignored while busy", {7'd0, busy}, 8'h01);
    cmdExit = 0; rdStrobe = 0;
    cyc = 2;
    while (busy && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    #1;
    check("R6 busy cycles before limit fail", 8'(cyc), 8'(LIMIT));
    check("R6 limit fail status", rdData & 8'hBF, 8'h20);
    t0 = rdData[6];
    rdStrobe = 1;
    @(negedge clk); @(negedge clk); #1;
    check("R5 toggle steady when idle", {7'd0, rdData[6]}, {7'd0, t0});
    rdStrobe = 0;
    addr = 4'd2; wrData = 8'h00; cmdProgram = 1;
    @(negedge clk);
    cmdProgram = 0; #1;
    check("R10 program ignored in status mode", {busy, rdData[6:0] & 7'h3F}, 8'h20);
    doExit();
    check("R10 exit returns array data", rdData, 8'hFF);
    @(negedge clk);

    // R6 boundary: verify on last allowed cycle
    runOp(1, 4'd3, 8'h0F, LIMIT - 1, 99, cyc);
    check("R6 verify on last cycle succeeds", rdData, 8'h0F);
    @(negedge clk);

    // R9 precedence over verify in the same cycle
    runOp(1, 4'd4, 8'h00, 1, 1, cyc);
    check("R9 supply fault wins over verify", rdData & 8'hBF, 8'h08);
    doExit();
    check("R9 word unchanged", rdData, 8'hFF);
    @(negedge clk);

    // R2 program wins over a simultaneous erase
    addr = 4'd7; wrData = 8'h5A; cmdProgram = 1; cmdErase = 1;
    @(negedge clk);
    cmdProgram = 0; cmdErase = 0; cellVerified = 1;
    @(negedge clk);
    cellVerified = 0; #1;
    check("R2 program priority", rdData, 8'h5A);
    addr = 4'd3; #1;
    check("R2 sector neighbour kept", rdData, 8'h0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule